// File: doc/BRIEF.md
# Serial Receive Interrupt Event Selector

This block drives the single receive interrupt request of a serial port receiver. A two-bit mode field in a control register chooses which of four receiver events raises the request. The events are a rising edge of the word-ready flag, a multichannel block or frame boundary strobe, a frame-sync pulse arriving asynchronously to the CPU clock, and the frame-sync error flag becoming set. The request leaves the block as a one-cycle pulse in the CPU clock domain.

Software writes the mode through a plain register write port and reads it back together with the live ready and error status bits. The frame-sync source is brought into the CPU clock through a synchronizer and then edge-detected. It keeps raising interrupts while the receiver is held in reset. The other three sources are masked during receiver reset. Every edge detector tracks its input in every mode, so a mode change never fires on a stale edge. The block has no streaming interface: all pins are plain control and status signals with no handshake.

Top module: `rx_irq_event_sel`

## Requirements
- R1: After block reset the mode field reads 00 and `irq` is low.
- R2: A write stores `cfg_wr_data[5:4]` as the mode (00 ready, 01 multichannel, 10 frame sync, 11 sync error). Read data returns the mode in bits 5:4 and zero in bits 7:6 and 3:2, whatever else was written.
- R3: In mode 00, a 0-to-1 change of `rx_ready` gives `irq` high for exactly one cycle, starting one clock edge after the change is sampled. A level held high gives no further pulse.
- R4: In mode 01 with `mc_enable` high, each cycle with `mc_block_end` or `mc_frame_end` high gives an `irq` pulse on the next edge.
- R5: In mode 01 with `mc_enable` low, boundary strobes never raise `irq`.
- R6: In mode 10, each pulse on `fs_async` gives exactly one `irq` cycle, seen three edges after the input rises. This holds even while `rcv_in_reset` is high.
- R7: In mode 11, a 0-to-1 change of `rx_sync_err` gives a one-cycle `irq` pulse on the next edge.
- R8: Read data bit 0 shows `rx_ready` and bit 1 shows `rx_sync_err` in every mode.
- R9: While `rcv_in_reset` is high, modes 00, 01 and 11 raise no interrupt.
- R10: Writing a new mode while the newly selected source is already high (ready or error flag, or a synchronized frame sync) raises no interrupt.
- R11: Events of sources that the mode does not select never raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low block reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 8 | Control register write data, mode in bits 5:4 |
| cfg_rd_data | output | 8 | Mode in 5:4, sync error in 1, ready in 0 |
| rx_ready | input | 1 | Receive word-ready flag |
| rx_sync_err | input | 1 | Frame-sync error flag |
| mc_enable | input | 1 | Multichannel selection mode active |
| mc_block_end | input | 1 | One-cycle strobe at a 16-channel block boundary |
| mc_frame_end | input | 1 | One-cycle strobe at the end of a multichannel frame |
| fs_async | input | 1 | Receive frame-sync pulse, asynchronous to clk |
| rcv_in_reset | input | 1 | Receiver held in reset |
| irq | output | 1 | One-cycle receive interrupt request |

## Verification
The hardest situation to reach is a mode switch onto a source whose edge history is already high. The case that matters most is frame sync, whose history sits behind a three-flop chain. The stimulus holds `fs_async` (or a flag) high under another mode for several cycles until the chain has settled, then writes the new mode and watches `irq` for the full synchronizer latency. A second hard case is frame sync under receiver reset. It is reached by asserting `rcv_in_reset` together with the pulse and checking that the pulse appears exactly once, three edges later.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;
  typedef enum logic [1:0] {
    SRC_RDY = 2'b00,
    SRC_MCB = 2'b01,
    SRC_FS  = 2'b10,
    SRC_ERR = 2'b11
  } irq_src_e;
endpackage

// File: rtl/rx_irq_rise.sv
// Per-bit rising-edge detectors on synchronous status flags; history always tracks.
module rx_irq_rise #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] hist_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q[i] <= 1'b0;
      else        hist_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~hist_q[i];

    // R3/R7: a detected rise is never followed by another rise in the next cycle
    a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> !rise[i]);
  end
endmodule

// File: rtl/rx_irq_fs_sync.sv
// Synchronizer chain plus edge detector for the asynchronous frame-sync input.
module rx_irq_fs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_in,
  output logic fs_rise
);
  localparam int CHAIN = STAGES + 1;
  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN-2:0], fs_in};
  end

  assign fs_rise = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R6: one interrupt per external pulse
  a_r6_fs_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    fs_rise |=> !fs_rise);
endmodule

// File: rtl/rx_irq_mode_reg.sv
// Holds the event-select field of the receive control register.
module rx_irq_mode_reg
  import rx_irq_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int MODE_LSB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output irq_src_e         mode
);
  localparam int MODE_MSB = MODE_LSB + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode <= SRC_RDY;
    else if (wr_en) mode <= irq_src_e'(wr_data[MODE_MSB:MODE_LSB]);
  end

  // R2: the field only moves on a write
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode));
endmodule

// File: rtl/rx_irq_event_sel.sv
module rx_irq_event_sel
  import rx_irq_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int MODE_LSB    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             rx_ready,
  input  logic             rx_sync_err,
  input  logic             mc_enable,
  input  logic             mc_block_end,
  input  logic             mc_frame_end,
  input  logic             fs_async,
  input  logic             rcv_in_reset,
  output logic             irq
);
  localparam int MODE_MSB = MODE_LSB + 1;
  localparam int FLAG_N   = 2;
  localparam int IDX_RDY  = 0;
  localparam int IDX_ERR  = 1;

  irq_src_e          mode_q;
  logic [FLAG_N-1:0] flag_rise;
  logic              fs_evt;
  logic              sel_evt;
  logic              irq_q;

  rx_irq_mode_reg #(.REG_W(REG_W), .MODE_LSB(MODE_LSB)) mode_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .mode(mode_q)
  );

  rx_irq_rise #(.W(FLAG_N)) rise_i (
    .clk(clk), .rst_n(rst_n), .lvl({rx_sync_err, rx_ready}), .rise(flag_rise)
  );

  rx_irq_fs_sync #(.STAGES(SYNC_STAGES)) fs_i (
    .clk(clk), .rst_n(rst_n), .fs_in(fs_async), .fs_rise(fs_evt)
  );

  always_comb begin
    unique case (mode_q)
      SRC_RDY: sel_evt = flag_rise[IDX_RDY] & ~rcv_in_reset;
      SRC_MCB: sel_evt = mc_enable & (mc_block_end | mc_frame_end) & ~rcv_in_reset;
      SRC_FS:  sel_evt = fs_evt;
      SRC_ERR: sel_evt = flag_rise[IDX_ERR] & ~rcv_in_reset;
      default: sel_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= sel_evt;
  end
  assign irq = irq_q;

  always_comb begin
    cfg_rd_data                    = '0;
    cfg_rd_data[MODE_MSB:MODE_LSB] = mode_q;
    cfg_rd_data[IDX_RDY]           = rx_ready;
    cfg_rd_data[IDX_ERR]           = rx_sync_err;
  end

  // R3: ready rise in mode 00 outside receiver reset raises the request
  a_r3_rdy_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SRC_RDY && !rcv_in_reset && $rose(rx_ready)) |=> irq);
  // R5: multichannel mode off means silence in mode 01
  a_r5_mc_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SRC_MCB && !mc_enable) |=> !irq);
  // R7: error flag set in mode 11 raises the request
  a_r7_err_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SRC_ERR && !rcv_in_reset && $rose(rx_sync_err)) |=> irq);
  // R9: receiver reset masks every source but frame sync
  a_r9_rcv_reset_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_in_reset && mode_q != SRC_FS) |=> !irq);
  // R6: in mode 10 the request only follows a synchronized frame-sync edge
  a_r6_fs_source: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SRC_FS && !fs_evt) |=> !irq);
endmodule

// File: tb/rx_irq_event_sel_tb_top.sv
module rx_irq_event_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic [7:0] cfg_rd_data;
  logic       rx_ready = 1'b0, rx_sync_err = 1'b0, mc_enable = 1'b0;
  logic       mc_block_end = 1'b0, mc_frame_end = 1'b0, fs_async = 1'b0;
  logic       rcv_in_reset = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_irq_event_sel dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .rx_ready(rx_ready), .rx_sync_err(rx_sync_err),
    .mc_enable(mc_enable), .mc_block_end(mc_block_end), .mc_frame_end(mc_frame_end),
    .fs_async(fs_async), .rcv_in_reset(rcv_in_reset), .irq(irq)
  );

  // row: {mode[1:0], rdy, err, mcen, blk, frm, rrst, exp_irq}
  localparam int NV = 18;
  localparam logic [8:0] VEC [NV] = '{
    9'b00_0000000,  // idle
    9'b00_1000001,  // R3 ready rise
    9'b00_1000000,  // R3 level held
    9'b00_0100000,  // R11 error ignored in mode 00
    9'b00_1000010,  // R9 ready rise masked
    9'b00_0000000,
    9'b01_0011001,  // R4 block boundary
    9'b01_0010000,
    9'b01_0010101,  // R4 frame end
    9'b01_0001000,  // R5 block strobe, mc off
    9'b01_0000100,  // R5 frame strobe, mc off
    9'b01_1011010,  // R9 strobe masked, R11 ready ignored
    9'b11_0000000,
    9'b11_0100001,  // R7 error rise
    9'b11_0100000,  // R7 level held
    9'b11_0000000,
    9'b11_1011000,  // R11 other sources ignored
    9'b11_0100010   // R9 error rise masked
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [1:0] m, input logic [7:0] other);
    cfg_wr_en = 1'b1;
    cfg_wr_data = other;
    cfg_wr_data[5:4] = m;
    mc_block_end = 1'b0;
    mc_frame_end = 1'b0;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  initial begin
    logic [1:0] cur_mode;
    cur_mode = 2'b00;
    @(negedge clk);
    check({7'b0, irq}, 8'h00, "R1 irq in reset");
    check(cfg_rd_data, 8'h00, "R1 mode in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({7'b0, irq}, 8'h00, "R1 irq after reset");
    check(cfg_rd_data & 8'h30, 8'h00, "R1 mode after reset");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][8:7] != cur_mode) begin
        write_mode(VEC[i][8:7], 8'h00);
        check({7'b0, irq}, 8'h00, "R10 no irq on mode write");
        cur_mode = VEC[i][8:7];
      end
      rx_ready     = VEC[i][6];
      rx_sync_err  = VEC[i][5];
      mc_enable    = VEC[i][4];
      mc_block_end = VEC[i][3];
      mc_frame_end = VEC[i][2];
      rcv_in_reset = VEC[i][1];
      @(negedge clk);
      check({7'b0, irq}, {7'b0, VEC[i][0]}, $sformatf("R3/R4/R5/R7/R9/R11 row %0d", i));
    end
    mc_block_end = 1'b0; mc_frame_end = 1'b0; rcv_in_reset = 1'b0;
    rx_ready = 1'b0; rx_sync_err = 1'b0; mc_enable = 1'b0;
    @(negedge clk);

    // R2: only bits 5:4 stored, other bits read zero
    write_mode(2'b10, 8'hCF);
    check(cfg_rd_data, 8'h20, "R2 readback");
    // R8: status visible in mode 10
    rx_ready = 1'b1; rx_sync_err = 1'b1;
    #1 check(cfg_rd_data, 8'h23, "R8 status mode 10");
    write_mode(2'b01, 8'h00);
    check(cfg_rd_data, 8'h13, "R8 status mode 01");
    rx_ready = 1'b0; rx_sync_err = 1'b0;
    #1 check(cfg_rd_data, 8'h10, "R8 status cleared");

    // R6: frame sync in mode 10 under receiver reset, latency 3, one pulse
    write_mode(2'b10, 8'h00);
    rcv_in_reset = 1'b1;
    fs_async = 1'b1;
    @(negedge clk); check({7'b0, irq}, 8'h00, "R6 edge 1");
    @(negedge clk); check({7'b0, irq}, 8'h00, "R6 edge 2");
    @(negedge clk); check({7'b0, irq}, 8'h01, "R6 edge 3");
    @(negedge clk); check({7'b0, irq}, 8'h00, "R6 edge 4");
    @(negedge clk); check({7'b0, irq}, 8'h00, "R6 held level");
    fs_async = 1'b0; rcv_in_reset = 1'b0;
    repeat (4) @(negedge clk);

    // R11: frame sync ignored in mode 00
    write_mode(2'b00, 8'h00);
    fs_async = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); check({7'b0, irq}, 8'h00, "R11 fs in mode 00");
    end
    // R10: switch to mode 10 with synchronized fs already high
    write_mode(2'b10, 8'h00);
    check({7'b0, irq}, 8'h00, "R10 fs switch write");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); check({7'b0, irq}, 8'h00, "R10 fs after switch");
    end
    fs_async = 1'b0;
    // R10: error flag high under mode 10, then switch to 11
    rx_sync_err = 1'b1;
    repeat (2) @(negedge clk);
    write_mode(2'b11, 8'h00);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); check({7'b0, irq}, 8'h00, "R10 err after switch");
    end
    // R10: ready flag high, switch to 00
    rx_ready = 1'b1;
    @(negedge clk);
    check({7'b0, irq}, 8'h00, "R11 ready in mode 11");
    write_mode(2'b00, 8'h00);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); check({7'b0, irq}, 8'h00, "R10 ready after switch");
    end

    // R1: block reset clears mode
    rst_n = 1'b0;
    @(negedge clk);
    check(cfg_rd_data & 8'h30, 8'h00, "R1 mode cleared");
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 20000);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule